// File: doc/BRIEF.md
# Multi-channel power-good delay supervisor

This block watches several supply-valid flags, one per channel. Each flag comes from an external threshold comparator and is already synchronous to `clk_i`. A channel asserts its power-good output only after its flag has stayed valid without a break for a programmed hold-off time. The hold-off is picked per channel by a 2-bit code, which is written through a simple write port. The codes give 100 ms, 500 ms, 1 s and 5 s. A parameter `CYC_PER_MS` sets the number of clock cycles in one millisecond, so a bench can shrink every delay.

A system reset output stays asserted until every channel reports good. A manual reset input counts only once it has been held for longer than `MR_QUAL_CYC` clocks. When it counts, it drops every power-good output and asserts the system reset. On release, each channel starts its own full hold-off again, provided its supply is still valid.

Top module: `pgood_supervisor`

## Requirements
- R1: The channel delay code maps as follows: 2'b00 gives 100 ms, 2'b01 gives 500 ms, 2'b10 gives 1 s and 2'b11 gives 5 s. A channel's power-good output goes high exactly `ms * CYC_PER_MS` rising clock edges after the first edge that samples its supply flag high, counting that edge, while manual reset is not qualified.
- R2: While `rst_ni` is low and just after it is released, all power-good outputs are 0 and `sys_rst_o` is 1. Every channel's delay code resets to 2'b00.
- R3: A write with `cfg_we_i` high stores `cfg_code_i` only into the channel selected by `cfg_ch_i`. The other channels keep their codes.
- R4: A power-good output rises only at an edge where its supply flag is sampled high and manual reset is not qualified.
- R5: At any edge that samples a channel's supply flag low, that channel's power-good output goes to 0. It stays at 0 while the flag stays low.
- R6: If a supply flag drops during the countdown, that channel's count restarts from zero. The full delay is then measured again from the next edge that samples the flag high.
- R7: When `mr_i` has been sampled high on more than `MR_QUAL_CYC` consecutive edges, all power-good outputs are 0 and `sys_rst_o` is 1 after that edge. This holds for as long as `mr_i` stays high.
- R8: A manual reset pulse sampled high on `MR_QUAL_CYC` or fewer consecutive edges leaves every power-good output unchanged.
- R9: After a qualified manual reset is released, each channel with a valid supply raises its output after its own programmed delay. The delay is counted from the first edge that samples `mr_i` low.
- R10: `sys_rst_o` is 0 exactly when every power-good output is 1.
- R11: A code write to a channel whose output is already good leaves that output good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sup_ok_i | input | NUM_CH | Per-channel supply-valid flags, synchronous to clk_i |
| mr_i | input | 1 | Manual reset request, active high |
| cfg_we_i | input | 1 | Delay-code write strobe |
| cfg_ch_i | input | CH_W | Channel selected by a write |
| cfg_code_i | input | 2 | Delay code to store |
| pg_o | output | NUM_CH | Per-channel power-good, 1 = good |
| sys_rst_o | output | 1 | System reset, 1 = held in reset |

## Verification
A delay code latched into the wrong channel shows up as a power-good edge at the wrong cycle count. A countdown that fails to clear shows up as an edge arriving early after a supply glitch. Either fault is visible on `pg_o` within one hold-off period of the stimulus. A manual-reset qualifier that is off by one either clears the outputs one edge after a pulse that should be ignored, or leaves them high one edge too long. The bench looks for both at the exact boundary edge. A per-cycle reference model of the counters is compared against `pg_o` and `sys_rst_o` at every cycle, so any divergence is reported in the cycle where it happens.

// File: rtl/pgsup_pkg.sv
package pgsup_pkg;

  typedef enum logic [1:0] {
    DLY_100MS = 2'b00,
    DLY_500MS = 2'b01,
    DLY_1S    = 2'b10,
    DLY_5S    = 2'b11
  } dly_code_e;

  // wide enough for the longest hold-off in ms
  localparam int unsigned MS_W = 13;

  function automatic logic [MS_W-1:0] dly_ms(dly_code_e c);
    case (c)
      DLY_100MS: return MS_W'(100);
      DLY_500MS: return MS_W'(500);
      DLY_1S:    return MS_W'(1000);
      default:   return MS_W'(5000);
    endcase
  endfunction

endpackage

// File: rtl/pgsup_ms_prescale.sv
module pgsup_ms_prescale #(
  parameter int unsigned CYC_PER_MS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned SW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [SW-1:0] LAST = SW'(CYC_PER_MS - 1);

  logic [SW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + SW'(1);
  end
endmodule

// File: rtl/pgsup_mr_qual.sv
module pgsup_mr_qual #(
  parameter int unsigned QUAL_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_i,
  output logic hold_o
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] SAT = QW'(QUAL_CYC);

  logic [QW-1:0] cnt_q;

  // qualified only while the request is still present: release is immediate
  assign hold_o = mr_i && (cnt_q == SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!mr_i)        cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + QW'(1);
  end
endmodule

// File: rtl/pgsup_chan.sv
module pgsup_chan
  import pgsup_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 100000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  dly_code_e code_i,
  output logic      pg_o
);
  logic            tick;
  logic            cnt_en;
  logic [MS_W-1:0] ms_q;
  logic            pg_q;

  assign cnt_en = run_i && !pg_q;

  pgsup_ms_prescale #(.CYC_PER_MS(CYC_PER_MS)) i_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!run_i),
    .en_i  (cnt_en),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_q <= '0;
      pg_q <= 1'b0;
    end else if (!run_i) begin
      ms_q <= '0;
      pg_q <= 1'b0;
    end else if (tick) begin
      if (ms_q >= dly_ms(code_i) - MS_W'(1)) pg_q <= 1'b1;
      else                                   ms_q <= ms_q + MS_W'(1);
    end
  end

  assign pg_o = pg_q;
endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
  import pgsup_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned CYC_PER_MS  = 100000,
  parameter int unsigned MR_QUAL_CYC = 500,
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] sup_ok_i,
  input  logic              mr_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [1:0]        cfg_code_i,
  output logic [NUM_CH-1:0] pg_o,
  output logic              sys_rst_o
);
  logic      mr_hold;
  dly_code_e code_q [NUM_CH];

  pgsup_mr_qual #(.QUAL_CYC(MR_QUAL_CYC)) i_mr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mr_i  (mr_i),
    .hold_o(mr_hold)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        code_q[ch] <= DLY_100MS;
      else if (cfg_we_i && (cfg_ch_i == CH_W'(ch)))
        code_q[ch] <= dly_code_e'(cfg_code_i);
    end

    pgsup_chan #(.CYC_PER_MS(CYC_PER_MS)) i_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (sup_ok_i[ch] && !mr_hold),
      .code_i(code_q[ch]),
      .pg_o  (pg_o[ch])
    );
  end

  assign sys_rst_o = ~&pg_o;
endmodule

// File: rtl/pgood_supervisor_chk.sv
module pgood_supervisor_chk #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned MR_QUAL_CYC = 500
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] sup_ok_i,
  input logic              mr_i,
  input logic [NUM_CH-1:0] pg_o,
  input logic              sys_rst_o
);
  localparam int unsigned QW = $clog2(MR_QUAL_CYC + 1);

  logic [QW-1:0] run_q;
  logic          mr_fire;

  // independent run-length count of the manual reset request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          run_q <= '0;
    else if (!mr_i)                       run_q <= '0;
    else if (run_q != QW'(MR_QUAL_CYC))   run_q <= run_q + QW'(1);
  end

  assign mr_fire = mr_i && (run_q == QW'(MR_QUAL_CYC));

  p_mr_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_fire |=> (pg_o == '0) && sys_rst_o);

  p_rst_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (&pg_o));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    p_low_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sup_ok_i[c] |=> !pg_o[c]);

    p_rise_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pg_o[c]) |-> ($past(sup_ok_i[c]) && !$past(mr_fire)));

    p_short_mr_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pg_o[c] && sup_ok_i[c] && !mr_fire) |=> pg_o[c]);
  end
endmodule

bind pgood_supervisor pgood_supervisor_chk #(
  .NUM_CH     (NUM_CH),
  .MR_QUAL_CYC(MR_QUAL_CYC)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sup_ok_i (sup_ok_i),
  .mr_i     (mr_i),
  .pg_o     (pg_o),
  .sys_rst_o(sys_rst_o)
);

// File: tb/test_pgood_supervisor.sv
`timescale 1ns/1ps
module test_pgood_supervisor;
  localparam int NCH = 4;
  localparam int CPM = 2;
  localparam int Q   = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] sup;
  logic           mr;
  logic           we;
  logic [1:0]     ch;
  logic [1:0]     code;
  logic [NCH-1:0] pg;
  logic           srst;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pgood_supervisor #(.NUM_CH(NCH), .CYC_PER_MS(CPM), .MR_QUAL_CYC(Q)) i_pgood_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .sup_ok_i(sup), .mr_i(mr),
    .cfg_we_i(we), .cfg_ch_i(ch), .cfg_code_i(code),
    .pg_o(pg), .sys_rst_o(srst)
  );

  function automatic int dly_cyc(logic [1:0] k);
    case (k)
      2'd0:    return 100 * CPM;
      2'd1:    return 500 * CPM;
      2'd2:    return 1000 * CPM;
      default: return 5000 * CPM;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // reference model built from the requirements
  int             mrun;
  int             cnt_m [NCH];
  logic [NCH-1:0] pg_m;
  logic [1:0]     code_m [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrun <= 0;
      pg_m <= '0;
      for (int i = 0; i < NCH; i++) begin
        cnt_m[i]  <= 0;
        code_m[i] <= 2'b00;
      end
    end else begin
      if (mr) mrun <= (mrun < Q) ? mrun + 1 : Q;
      else    mrun <= 0;
      for (int i = 0; i < NCH; i++) begin
        if (!sup[i] || (mr && mrun == Q)) begin
          cnt_m[i] <= 0;
          pg_m[i]  <= 1'b0;
        end else if (!pg_m[i]) begin
          cnt_m[i] <= cnt_m[i] + 1;
          if (cnt_m[i] + 1 >= dly_cyc(code_m[i])) pg_m[i] <= 1'b1;
        end
      end
      if (we) code_m[ch] <= code;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 R5 R10 model pg", 32'(pg), 32'(pg_m));
      check("R10 model rst", 32'(srst), 32'(~&pg_m));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int c, input int k);
    ch = 2'(c); code = 2'(k); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic meas(input int c, output int n);
    n = 0;
    while (!pg[c] && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    int n;
    int t [NCH];
    int mr_left;
    void'($urandom(32'd7741));
    rst_n = 1'b0; sup = '0; mr = 1'b0; we = 1'b0; ch = '0; code = '0;
    cyc(3);
    check("R2 pg in reset", 32'(pg), 32'h0);
    check("R2 rst in reset", 32'(srst), 32'h1);
    rst_n = 1'b1;
    cyc(2);
    check("R2 pg after reset", 32'(pg), 32'h0);
    check("R2 rst after reset", 32'(srst), 32'h1);

    // default code is 100 ms
    sup[1] = 1'b1;
    meas(1, n);
    check("R2 default delay", 32'(n), 32'(100 * CPM));
    sup[1] = 1'b0;
    cyc(1);

    // every code on one channel
    for (int k = 0; k < 4; k++) begin
      wr(0, k);
      sup[0] = 1'b1;
      meas(0, n);
      check("R1 code delay", 32'(n), 32'(dly_cyc(2'(k))));
      sup[0] = 1'b0;
      cyc(1);
      check("R5 drop clears", 32'(pg[0]), 32'h0);
    end

    // glitch mid-count restarts
    wr(0, 0);
    sup[0] = 1'b1;
    cyc(150);
    check("R6 still counting", 32'(pg[0]), 32'h0);
    sup[0] = 1'b0;
    cyc(1);
    sup[0] = 1'b1;
    meas(0, n);
    check("R6 restart delay", 32'(n), 32'(100 * CPM));

    // per-channel codes
    sup = '0;
    cyc(1);
    wr(0, 0); wr(1, 0); wr(2, 3); wr(3, 0);
    sup = '1;
    cyc(100 * CPM);
    check("R3 independent codes", 32'(pg), 32'hB);
    check("R10 rst while one pending", 32'(srst), 32'h1);
    cyc(4900 * CPM);
    check("R3 slow channel done", 32'(pg), 32'hF);
    check("R10 rst released", 32'(srst), 32'h0);

    // code write while good
    wr(0, 3);
    cyc(5);
    check("R11 write keeps good", 32'(pg), 32'hF);

    // setup for manual reset
    sup = '0;
    cyc(1);
    wr(0, 0); wr(1, 1); wr(2, 0); wr(3, 1);
    sup = '1;
    cyc(500 * CPM);
    check("R9 setup all good", 32'(pg), 32'hF);

    // pulse of exactly Q edges: ignored
    mr = 1'b1;
    cyc(Q);
    mr = 1'b0;
    cyc(2);
    check("R8 short pulse ignored", 32'(pg), 32'hF);
    check("R8 rst unaffected", 32'(srst), 32'h0);

    // Q+1 edges: qualified
    mr = 1'b1;
    cyc(Q + 1);
    check("R7 mr clears pg", 32'(pg), 32'h0);
    check("R7 mr asserts rst", 32'(srst), 32'h1);
    cyc(20);
    check("R7 mr holds", 32'(pg), 32'h0);

    mr = 1'b0;
    for (int c = 0; c < NCH; c++) t[c] = 0;
    for (int i = 1; i <= 1100; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pg[c] && t[c] == 0) t[c] = i;
    end
    check("R9 ch0 release delay", 32'(t[0]), 32'(100 * CPM));
    check("R9 ch1 release delay", 32'(t[1]), 32'(500 * CPM));
    check("R9 ch2 release delay", 32'(t[2]), 32'(100 * CPM));
    check("R9 ch3 release delay", 32'(t[3]), 32'(500 * CPM));

    // random phase, checked by the model each cycle
    mr_left = 0;
    for (int i = 0; i < 30000; i++) begin
      if (mr_left > 0) begin
        mr = 1'b1;
        mr_left--;
      end else begin
        mr = 1'b0;
        if ($urandom_range(0, 1999) == 0) mr_left = $urandom_range(1, 2 * Q + 2);
      end
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 299) == 0) sup[c] = ~sup[c];
      we = 1'b0;
      if ($urandom_range(0, 99) == 0) begin
        int c;
        c = $urandom_range(0, NCH - 1);
        if (!sup[c]) begin
          ch = 2'(c);
          code = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
          we = 1'b1;
        end
      end
      @(negedge clk);
    end
    we = 1'b0;
    mr = 1'b0;
    cyc(2);

    summary();
    $finish;
  end
endmodule